// File: doc/BRIEF.md
# Circular Reorder Buffer with Rollback

This block keeps the in-flight instructions of an out-of-order core in program order so that their results reach architectural state in that same order. It is a ring of entries addressed by two pointers. One marks the next free slot, the other marks the oldest entry still waiting. The decode stage claims one slot per cycle and records the operation and destination register. Execution units may finish in any order. Each one writes its result and an exception cause back into the slot index it was handed. A result stays inside the buffer until its entry is the oldest and has finished. Only then is it presented on the retire port, so a store held here cannot reach memory early.

Two recovery paths exist. When the oldest finished entry carries a non-zero cause, the buffer empties in one cycle: the free pointer is set equal to the oldest pointer and a redirect to the handler is raised. When a branch turns out to be mispredicted, the free pointer is moved back to the slot just after the branch, and every younger slot is released. Completion writes that arrive for released slots are dropped.

Top module: `rob_ring`

## Requirements
- R1: Slots are handed out in program order. `alloc_idx` shows the slot the next accepted allocation takes. Each accepted allocation adds one to `occupancy` unless an entry retires in the same cycle.
- R2: Each pointer carries one wrap bit above its index, so a full buffer and an empty one can be told apart. While `occupancy` equals DEPTH, `alloc_ready` is low, a request is refused, and `occupancy` never exceeds DEPTH.
- R3: At most one entry retires per cycle. It is always the oldest, and only once it has completed. In that cycle `commit_valid` is high and `commit_op`, `commit_dest` and `commit_data` carry that entry's fields.
- R4: A younger entry that has completed is not presented while an older one is still waiting. Completion order has no effect on retire order.
- R5: A completed oldest entry with a non-zero cause does not retire. Instead `exc_flush` is high and `exc_cause` shows the cause. In the next cycle `occupancy` is 0 and `alloc_idx` equals the slot that held the faulting entry.
- R6: A mispredict that names a live slot sets `occupancy` in the next cycle to the age of the branch plus one, less one if the oldest entry retires in that cycle. The next allocation then takes the slot after the branch.
- R7: A completion aimed at a slot that is not in use is ignored. When that slot is later reallocated, it does not retire until it receives a completion of its own.
- R8: When the oldest entry faults in the same cycle as a mispredict, the fault flush wins and the buffer ends up empty.
- R9: `alloc_ready` is low in any cycle in which a mispredict is presented or a fault flush takes place.
- R10: After reset `occupancy` is 0, `alloc_idx` is 0, `alloc_ready` is 1, and `commit_valid` and `exc_flush` are 0.
- R11: A mispredict that names a slot not in use changes neither pointer.
- R12: Slot indices wrap from DEPTH-1 back to 0. Age comparisons for rollback are made relative to the oldest pointer, across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Decode requests a slot |
| alloc_op | input | OP_W | Operation code of the new entry |
| alloc_dest | input | DEST_W | Destination register of the new entry |
| alloc_ready | output | 1 | A request in this cycle is accepted |
| alloc_idx | output | $clog2(DEPTH) | Slot the next accepted allocation takes |
| done_valid | input | 1 | An execution unit reports completion |
| done_idx | input | $clog2(DEPTH) | Slot being completed |
| done_data | input | DATA_W | Result value |
| done_cause | input | CAUSE_W | Exception cause, 0 meaning none |
| mispredict | input | 1 | A branch entry was mispredicted |
| mispredict_idx | input | $clog2(DEPTH) | Slot of that branch |
| commit_valid | output | 1 | Oldest entry retires this cycle |
| commit_op | output | OP_W | Operation of the retiring entry |
| commit_dest | output | DEST_W | Destination of the retiring entry |
| commit_data | output | DATA_W | Result of the retiring entry |
| exc_flush | output | 1 | Oldest entry faults; buffer empties, redirect to handler |
| exc_cause | output | CAUSE_W | Cause of the fault, 0 when none |
| occupancy | output | $clog2(DEPTH)+1 | Number of entries in use |

## Verification
Several invariants are checked on every cycle. The count of live slots always equals the pointer distance. Occupancy never exceeds the depth. The oldest pointer never moves by more than one. A fault always leaves the buffer empty a cycle later. A rollback always leaves exactly the branch's age plus one entries, less any retirement. Completions aimed at dead slots never change a slot's completed flag. Other behaviours need an ordered history of traffic, and only the bench scenarios can show them: results retiring in program order after out-of-order completion, the fields presented at retire, the fault winning over a same-cycle mispredict, and a stale completion not letting a reused slot retire early.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // What the oldest entry does in the current cycle
  typedef enum logic [1:0] {
    HEAD_WAIT   = 2'd0,
    HEAD_RETIRE = 2'd1,
    HEAD_TRAP   = 2'd2
  } head_act_e;

  // Distance of a slot from the oldest slot, walking forward round the ring.
  // depth must be a power of two.
  function automatic int unsigned ring_age(int unsigned slot, int unsigned oldest,
                                           int unsigned depth);
    return (slot + depth - oldest) & (depth - 1);
  endfunction

endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic          mispredict,
  input  logic [IW-1:0] mis_idx,
  input  logic          mis_live,
  input  logic          head_live,
  input  logic          head_done,
  input  logic          head_trap,
  output logic [PW-1:0] head_q,
  output logic [PW-1:0] tail_q,
  output head_act_e     act,
  output logic          do_alloc,
  output logic          do_roll,
  output logic [IW-1:0] roll_age,
  output logic          alloc_ready,
  output logic [PW-1:0] occupancy
);

  logic          full;
  logic [PW-1:0] head_d, tail_d;

  always_comb begin
    full = (head_q[IW] != tail_q[IW]) && (head_q[IW-1:0] == tail_q[IW-1:0]);
    act  = HEAD_WAIT;
    if (head_live && head_done) act = head_trap ? HEAD_TRAP : HEAD_RETIRE;
    alloc_ready = !full && (act != HEAD_TRAP) && !mispredict;
    do_alloc    = alloc_valid && alloc_ready;
    do_roll     = mispredict && mis_live && (act != HEAD_TRAP);
    roll_age    = IW'(ring_age(32'(mis_idx), 32'(head_q[IW-1:0]), DEPTH));
    occupancy   = tail_q - head_q;
    head_d      = head_q + PW'(act == HEAD_RETIRE);
    if (act == HEAD_TRAP)  tail_d = head_q;
    else if (do_roll)      tail_d = head_q + PW'(roll_age) + PW'(1);
    else if (do_alloc)     tail_d = tail_q + PW'(1);
    else                   tail_d = tail_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= PW'(DEPTH)); // R2
  AST_TRAP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    act == HEAD_TRAP |=> occupancy == '0); // R5
  AST_ROLL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    do_roll |=> (occupancy + PW'($past(act == HEAD_RETIRE))) == (PW'($past(roll_age)) + PW'(1))); // R6
  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(head_q - $past(head_q)) <= PW'(1)); // R3

endmodule

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int OP_W    = 4,
  parameter int DEST_W  = 5,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 4,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               do_alloc,
  input  logic [IW-1:0]      alloc_idx,
  input  logic [OP_W-1:0]    alloc_op,
  input  logic [DEST_W-1:0]  alloc_dest,
  input  logic               done_valid,
  input  logic [IW-1:0]      done_idx,
  input  logic [DATA_W-1:0]  done_data,
  input  logic [CAUSE_W-1:0] done_cause,
  input  head_act_e          act,
  input  logic               do_roll,
  input  logic [IW-1:0]      roll_age,
  input  logic [IW-1:0]      head_idx,
  input  logic [IW-1:0]      mis_idx,
  output logic [DEPTH-1:0]   live_vec,
  output logic               mis_live,
  output logic               head_live,
  output logic               head_done,
  output logic               head_trap,
  output logic [OP_W-1:0]    head_op,
  output logic [DEST_W-1:0]  head_dest,
  output logic [DATA_W-1:0]  head_data,
  output logic [CAUSE_W-1:0] head_cause
);

  logic               live_q  [DEPTH];
  logic               done_q  [DEPTH];
  logic [OP_W-1:0]    op_q    [DEPTH];
  logic [DEST_W-1:0]  dest_q  [DEPTH];
  logic [DATA_W-1:0]  data_q  [DEPTH];
  logic [CAUSE_W-1:0] cause_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [IW-1:0] age;
    logic          kill, take, fill;

    always_comb begin
      age  = IW'(ring_age(32'(g), 32'(head_idx), DEPTH));
      take = do_alloc && (alloc_idx == IW'(g));
      fill = done_valid && (done_idx == IW'(g)) && live_q[g];
      kill = (act == HEAD_TRAP) || (do_roll && (age > roll_age)) ||
             ((act == HEAD_RETIRE) && (head_idx == IW'(g)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q[g] <= 1'b0;
        done_q[g] <= 1'b0;
      end else begin
        if (kill)      live_q[g] <= 1'b0;
        else if (take) live_q[g] <= 1'b1;
        if (take)      done_q[g] <= 1'b0;
        else if (fill) done_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (take) begin
        op_q[g]   <= alloc_op;
        dest_q[g] <= alloc_dest;
      end
      if (fill) begin
        data_q[g]  <= done_data;
        cause_q[g] <= done_cause;
      end
    end

    AST_STALE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && (done_idx == IW'(g)) && !live_q[g] && !take) |=> done_q[g] == $past(done_q[g])); // R7
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) live_vec[i] = live_q[i];
    mis_live   = live_q[mis_idx];
    head_live  = live_q[head_idx];
    head_done  = done_q[head_idx];
    head_op    = op_q[head_idx];
    head_dest  = dest_q[head_idx];
    head_data  = data_q[head_idx];
    head_cause = cause_q[head_idx];
    head_trap  = head_cause != '0;
  end

endmodule

// File: rtl/rob_ring.sv
module rob_ring
  import rob_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int OP_W    = 4,
  parameter int DEST_W  = 5,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 4,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  input  logic [OP_W-1:0]    alloc_op,
  input  logic [DEST_W-1:0]  alloc_dest,
  output logic               alloc_ready,
  output logic [IW-1:0]      alloc_idx,
  input  logic               done_valid,
  input  logic [IW-1:0]      done_idx,
  input  logic [DATA_W-1:0]  done_data,
  input  logic [CAUSE_W-1:0] done_cause,
  input  logic               mispredict,
  input  logic [IW-1:0]      mispredict_idx,
  output logic               commit_valid,
  output logic [OP_W-1:0]    commit_op,
  output logic [DEST_W-1:0]  commit_dest,
  output logic [DATA_W-1:0]  commit_data,
  output logic               exc_flush,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [PW-1:0]      occupancy
);

  // Named internal events
  logic [PW-1:0]      head_q, tail_q;
  head_act_e          act;
  logic               do_alloc, do_roll, mis_live;
  logic [IW-1:0]      roll_age;
  logic [DEPTH-1:0]   live_vec;
  logic               head_live, head_done, head_trap;
  logic [CAUSE_W-1:0] head_cause;

  rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid),
    .mispredict(mispredict), .mis_idx(mispredict_idx), .mis_live(mis_live),
    .head_live(head_live), .head_done(head_done), .head_trap(head_trap),
    .head_q(head_q), .tail_q(tail_q), .act(act), .do_alloc(do_alloc),
    .do_roll(do_roll), .roll_age(roll_age), .alloc_ready(alloc_ready),
    .occupancy(occupancy)
  );

  rob_store #(.DEPTH(DEPTH), .OP_W(OP_W), .DEST_W(DEST_W), .DATA_W(DATA_W),
              .CAUSE_W(CAUSE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .do_alloc(do_alloc), .alloc_idx(tail_q[IW-1:0]),
    .alloc_op(alloc_op), .alloc_dest(alloc_dest), .done_valid(done_valid),
    .done_idx(done_idx), .done_data(done_data), .done_cause(done_cause),
    .act(act), .do_roll(do_roll), .roll_age(roll_age),
    .head_idx(head_q[IW-1:0]), .mis_idx(mispredict_idx), .live_vec(live_vec),
    .mis_live(mis_live), .head_live(head_live), .head_done(head_done),
    .head_trap(head_trap), .head_op(commit_op), .head_dest(commit_dest),
    .head_data(commit_data), .head_cause(head_cause)
  );

  always_comb begin
    alloc_idx    = tail_q[IW-1:0];
    commit_valid = act == HEAD_RETIRE;
    exc_flush    = act == HEAD_TRAP;
    exc_cause    = exc_flush ? head_cause : '0;
  end

  AST_LIVE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(live_vec) == 32'(occupancy)); // R1
  AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_flush && mispredict) |=> occupancy == '0); // R8

endmodule

// File: tb/rob_ring_test.sv
module rob_ring_test;
  localparam int D = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc_valid = 0;
  logic [3:0] alloc_op = 0;
  logic [4:0] alloc_dest = 0;
  logic       alloc_ready;
  logic [2:0] alloc_idx;
  logic       done_valid = 0;
  logic [2:0] done_idx = 0;
  logic [31:0] done_data = 0;
  logic [3:0] done_cause = 0;
  logic       mispredict = 0;
  logic [2:0] mispredict_idx = 0;
  logic       commit_valid;
  logic [3:0] commit_op;
  logic [4:0] commit_dest;
  logic [31:0] commit_data;
  logic       exc_flush;
  logic [3:0] exc_cause;
  logic [3:0] occupancy;

  rob_ring #(.DEPTH(D)) uut (.*);

  always #10 clk = ~clk;

  typedef struct {int op; int dest; longint data; int cause; bit fin;} ment_t;
  ment_t q[$];
  int mh = 0;
  int n_tests = 0, n_fail = 0;
  bit e_ready, e_commit, e_flush;

  task automatic chk(string tag, string what, longint got, longint exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic compare();
    int sz = q.size();
    bit h_ok = (sz > 0) && q[0].fin;
    e_flush  = h_ok && (q[0].cause != 0);
    e_commit = h_ok && (q[0].cause == 0);
    e_ready  = (sz < D) && !e_flush && !mispredict;
    chk("R1", "occupancy", occupancy, sz);
    chk("R1", "alloc_idx", alloc_idx, (mh + sz) % D);
    chk("R2", "alloc_ready", alloc_ready, e_ready);
    chk("R3", "commit_valid", commit_valid, e_commit);
    if (e_commit) begin
      chk("R3", "commit_op", commit_op, q[0].op);
      chk("R3", "commit_dest", commit_dest, q[0].dest);
      chk("R3", "commit_data", commit_data, q[0].data);
    end
    chk("R5", "exc_flush", exc_flush, e_flush);
    if (e_flush) chk("R5", "exc_cause", exc_cause, q[0].cause);
  endtask

  task automatic model_step();
    int sz = q.size();
    if (e_flush) q.delete();
    else begin
      if (done_valid) begin
        int p = (int'(done_idx) - mh + D) % D;
        if (p < sz) begin
          ment_t t = q[p];
          t.fin = 1; t.data = done_data; t.cause = done_cause;
          q[p] = t;
        end
      end
      if (mispredict) begin
        int p = (int'(mispredict_idx) - mh + D) % D;
        if (p < sz) while (q.size() > p + 1) void'(q.pop_back());
      end
      if (e_commit) begin
        void'(q.pop_front());
        mh = (mh + 1) % D;
      end
      if (alloc_valid && e_ready) begin
        ment_t n;
        n.op = alloc_op; n.dest = alloc_dest; n.data = 0; n.cause = 0; n.fin = 0;
        q.push_back(n);
      end
    end
  endtask

  // Compare before the edge, advance the model at the edge, return at the next falling edge
  task automatic tick();
    #1 compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle_in();
    alloc_valid = 0; done_valid = 0; mispredict = 0; done_cause = 0;
  endtask

  task automatic alloc(int op, int dest);
    idle_in(); alloc_valid = 1; alloc_op = 4'(op); alloc_dest = 5'(dest);
  endtask

  task automatic finish(int idx, int data, int cause);
    idle_in(); done_valid = 1; done_idx = 3'(idx); done_data = 32'(data);
    done_cause = 4'(cause);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk("R10", "occupancy", occupancy, 0);
    chk("R10", "alloc_idx", alloc_idx, 0);
    chk("R10", "alloc_ready", alloc_ready, 1);
    chk("R10", "commit_valid", commit_valid, 0);
    chk("R10", "exc_flush", exc_flush, 0);

    // Fill the ring in order (R1), then a refused request when full (R2)
    for (int i = 0; i < D; i++) begin
      alloc(i + 1, i + 10);
      #1 chk("R1", "slot order", alloc_idx, i);
      tick();
    end
    alloc(9, 9);
    #1 chk("R2", "ready when full", alloc_ready, 0);
    tick();
    idle_in();
    #1 chk("R2", "occupancy when full", occupancy, D);

    // Out-of-order completion, in-order retire (R4, R3)
    finish(2, 200, 0); tick();
    finish(1, 100, 0); tick();
    idle_in();
    #1 chk("R4", "younger done, oldest waiting", commit_valid, 0);
    finish(0, 50, 0); tick();
    idle_in();
    #1 begin
      chk("R3", "retire flag", commit_valid, 1);
      chk("R3", "retire data", commit_data, 50);
    end
    repeat (3) tick();

    // Fault at slot 4 after slot 3 retires (R5)
    finish(4, 400, 3); tick();
    finish(3, 300, 0); tick();
    idle_in(); tick();
    #1 begin
      chk("R5", "flush raised", exc_flush, 1);
      chk("R5", "flush cause", exc_cause, 3);
      chk("R5", "no retire on fault", commit_valid, 0);
    end
    tick();
    #1 begin
      chk("R5", "empty after flush", occupancy, 0);
      chk("R5", "restart slot", alloc_idx, 4);
    end

    // Wrap and rollback (R12, R9, R6)
    for (int i = 0; i < 6; i++) begin alloc(i, i); tick(); end
    idle_in();
    #1 begin
      chk("R12", "wrapped slot", alloc_idx, 2);
      chk("R12", "occupancy across wrap", occupancy, 6);
    end
    alloc(7, 7); mispredict = 1; mispredict_idx = 3'd6;
    #1 chk("R9", "ready during mispredict", alloc_ready, 0);
    tick();
    idle_in();
    #1 begin
      chk("R6", "occupancy after rollback", occupancy, 3);
      chk("R6", "slot after branch", alloc_idx, 7);
    end

    // Stale completion to a released slot (R7)
    finish(0, 999, 5); tick();
    alloc(2, 20); tick();
    alloc(3, 21); tick();
    for (int i = 4; i < 8; i++) begin finish(i, i * 11, 0); tick(); end
    idle_in(); tick();
    #1 begin
      chk("R7", "reused slot not retired", commit_valid, 0);
      chk("R7", "reused slot not faulted", exc_flush, 0);
      chk("R7", "reused slot still live", occupancy, 1);
    end
    finish(0, 77, 0); tick();
    idle_in(); repeat (2) tick();

    // Mispredict naming a free slot (R11)
    for (int i = 0; i < 3; i++) begin alloc(i, i); tick(); end
    idle_in(); mispredict = 1; mispredict_idx = 3'd5; tick();
    idle_in();
    #1 begin
      chk("R11", "occupancy unchanged", occupancy, 3);
      chk("R11", "next slot unchanged", alloc_idx, 4);
    end

    // Fault and mispredict together (R8)
    finish(1, 5, 2); tick();
    idle_in(); mispredict = 1; mispredict_idx = 3'd2;
    #1 chk("R8", "flush raised", exc_flush, 1);
    tick();
    idle_in();
    #1 begin
      chk("R8", "empty after combined event", occupancy, 0);
      chk("R8", "restart slot", alloc_idx, 1);
    end

    // Mixed traffic against the model on every clock
    for (int c = 0; c < 3000; c++) begin
      int r = $urandom;
      idle_in();
      alloc_valid = (r & 3) != 0;
      alloc_op = 4'($urandom); alloc_dest = 5'($urandom);
      done_valid = ((r >> 2) & 1) != 0;
      done_idx = 3'($urandom); done_data = $urandom;
      done_cause = (((r >> 4) % 19) == 0) ? 4'(1 + (r >> 12) % 15) : 4'd0;
      mispredict = ((r >> 9) % 23) == 0;
      mispredict_idx = 3'($urandom);
      tick();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule